// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

A purely combinational adder of parameterised width that sums two unsigned operands and a carry input. The carry into every bit position comes from a radix-2 prefix network. Each node of that network merges two (generate, propagate) pairs with AND-OR logic. The carry input enters the network as an extra generate term below bit 0. Because of this, the carry into bit i is the group generate over every position from the carry input up to bit i-1. The carry output is the group generate across all positions.

Two parameters choose the structure. `KS` picks the prefix topology:

- 0 gives a minimum-depth network with unbounded fanout, where each level joins the upper half of a block to the top of its lower half.
- 1 gives a network with a fanout of two at every node. At each level every node takes a partner a fixed distance below it. This costs more nodes.

`CSEL` picks how the sum bits are formed:

- 0 is lookahead mode. Each sum bit is the propagate bit XOR the carry into that bit.
- 1 is carry-select mode. Both candidate sum bits, for carry 0 and for carry 1, are formed first. A multiplexer driven by the prefix carry then picks one.

All four combinations give the same arithmetic result. The adder is used wherever a carry-propagate addition is needed and the designer wants to trade area against depth.

Top module: `prefix_adder`

## Requirements
- R1: For any `a`, `b` and `cin`, the concatenation {`cout`, `sum`} equals a + b + cin as a W+1-bit unsigned value.
- R2: With `CSEL`=1 (carry-select sums), the output is identical to R1 under both topologies.
- R3: With `KS`=1 (bounded-fanout topology), the output is identical to R1 under both sum modes.
- R4: With `KS`=0 and `CSEL`=0, which are the defaults, the output is identical to R1.
- R5: `cout` is 1 exactly when a + b + cin is at least 2^W.
- R6: When every bit of a XOR b is 1, `cout` equals `cin`. `sum` is then all ones for `cin`=0 and all zeros for `cin`=1.
- R7: When `a` and `b` are both zero, `sum` equals `cin` in bit 0 and zero in every other bit, and `cout` is 0.
- R8: When `a` and `b` are both all ones, `cout` is 1. `sum` has ones in bits W-1..1 and `cin` in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry input, weight 1 |
| sum | output | W | Low W bits of the total |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
Carry generation and carry propagation can meet in a single addition. In that case the carry input, or a generate far down the word, must ripple through a run of propagate bits into `cout`. Operand pairs of the forms all-ones plus one, alternating patterns with their complement, and both operands all ones make the carry input and the deepest prefix node decide the result in the same addition. The bench also sweeps every operand pair and carry at width 8 for all four structures, and random words at width 32. Each result is judged against the integer sum that the bench computes itself.

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int W    = 32,
  parameter bit KS   = 1'b0,
  parameter bit CSEL = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int N = W + 1;
  localparam int L = $clog2(N);

  logic [W-1:0] hg, hp;
  logic [W:0]   cy;

  assign hg = a & b;
  assign hp = a ^ b;

  genvar k, j;
  for (k = 0; k <= L; k++) begin : lvl
    logic [W:0] gv, pv;
    if (k == 0) begin : seed
      assign gv = {hg, cin};
      assign pv = {hp, 1'b0};
    end else begin : comb
      localparam int D = 1 << (k - 1);
      for (j = 0; j < N; j++) begin : node
        localparam bit ACTIVE  = KS ? (j >= D) : (((j >> (k - 1)) & 1) == 1);
        localparam int PARTNER = KS ? (j - D) : (((j >> k) << k) + D - 1);
        if (ACTIVE) begin : op
          assign gv[j] = lvl[k-1].gv[j] | (lvl[k-1].pv[j] & lvl[k-1].gv[PARTNER]);
          assign pv[j] = lvl[k-1].pv[j] & lvl[k-1].pv[PARTNER];
        end else begin : pass
          assign gv[j] = lvl[k-1].gv[j];
          assign pv[j] = lvl[k-1].pv[j];
        end
      end
    end
  end

  assign cy   = lvl[L].gv;
  assign cout = cy[W];

  if (CSEL) begin : g_select
    logic [W-1:0] cand0, cand1;
    assign cand0 = hp;
    assign cand1 = ~hp;
    for (j = 0; j < W; j++) begin : mux
      assign sum[j] = cy[j] ? cand1[j] : cand0[j];
    end
  end else begin : g_lookahead
    assign sum = hp ^ cy[W-1:0];
  end

  always_comb begin
    p_total_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("R1 total mismatch");
    p_group_prop_r1: assert (lvl[L].pv == '0)
      else $error("R1 final group propagate not cleared");
    p_carry_seed_r7: assert (cy[0] == cin)
      else $error("R7 carry into bit 0 differs from cin");
    p_cout_msb_r5: assert (cout == (hg[W-1] | (hp[W-1] & cy[W-1])))
      else $error("R5 carry-out inconsistent with top bit");
    p_propagate_r6: assert (!(&hp) || (cout == cin))
      else $error("R6 full propagate");
    p_kill_r7: assert ((|(a | b)) || ((sum == W'(cin)) && !cout))
      else $error("R7 all-zero operands");
    p_generate_r8: assert (!(&hg) || cout)
      else $error("R8 all-one operands");
  end
endmodule

// File: tb/tb_prefix_adder.sv
module tb_prefix_adder;
  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic [7:0]  a8, b8;
  logic        c8;
  logic [31:0] a32, b32;
  logic        c32;
  logic [7:0]  s8 [4];
  logic        co8 [4];
  logic [31:0] s32 [4];
  logic        co32 [4];

  prefix_adder #(.W(8), .KS(1'b0), .CSEL(1'b0)) dut        (.a(a8), .b(b8), .cin(c8), .sum(s8[0]), .cout(co8[0]));
  prefix_adder #(.W(8), .KS(1'b0), .CSEL(1'b1)) dut_lf_sel (.a(a8), .b(b8), .cin(c8), .sum(s8[1]), .cout(co8[1]));
  prefix_adder #(.W(8), .KS(1'b1), .CSEL(1'b0)) dut_ks_cla (.a(a8), .b(b8), .cin(c8), .sum(s8[2]), .cout(co8[2]));
  prefix_adder #(.W(8), .KS(1'b1), .CSEL(1'b1)) dut_ks_sel (.a(a8), .b(b8), .cin(c8), .sum(s8[3]), .cout(co8[3]));
  prefix_adder #(.W(32), .KS(1'b0), .CSEL(1'b0)) w32_lf_cla (.a(a32), .b(b32), .cin(c32), .sum(s32[0]), .cout(co32[0]));
  prefix_adder #(.W(32), .KS(1'b0), .CSEL(1'b1)) w32_lf_sel (.a(a32), .b(b32), .cin(c32), .sum(s32[1]), .cout(co32[1]));
  prefix_adder #(.W(32), .KS(1'b1), .CSEL(1'b0)) w32_ks_cla (.a(a32), .b(b32), .cin(c32), .sum(s32[2]), .cout(co32[2]));
  prefix_adder #(.W(32), .KS(1'b1), .CSEL(1'b1)) w32_ks_sel (.a(a32), .b(b32), .cin(c32), .sum(s32[3]), .cout(co32[3]));

  typedef struct {
    logic [8:0]  e8;
    logic [32:0] e32;
    string       tag;
  } item_t;

  item_t q[$];
  int tests = 0;
  int fails = 0;
  string nm[4] = '{"R4 LF lookahead", "R2 LF select", "R3 KS lookahead", "R2 R3 KS select"};

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] x, input logic [7:0] y, input logic c,
                       input logic [31:0] xx, input logic [31:0] yy, input logic cc, input string tag);
    item_t it;
    @(negedge clk);
    a8 = x; b8 = y; c8 = c;
    a32 = xx; b32 = yy; c32 = cc;
    it.e8  = {1'b0, x} + {1'b0, y} + {8'd0, c};
    it.e32 = {1'b0, xx} + {1'b0, yy} + {32'd0, cc};
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    item_t it;
    if (rst_n && q.size() > 0) begin
      it = q.pop_front();
      for (int i = 0; i < 4; i++) begin
        chk({co8[i], s8[i]} == it.e8, {it.tag, " w8 ", nm[i]}, 64'({co8[i], s8[i]}), 64'(it.e8));
        chk({co32[i], s32[i]} == it.e32, {it.tag, " w32 ", nm[i]}, 64'({co32[i], s32[i]}), 64'(it.e32));
        chk(co8[i] == it.e8[8], {it.tag, " R5 carry-out w8 ", nm[i]}, 64'(co8[i]), 64'(it.e8[8]));
        chk(co32[i] == it.e32[32], {it.tag, " R5 carry-out w32 ", nm[i]}, 64'(co32[i]), 64'(it.e32[32]));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    drive(8'h00, 8'h00, 1'b0, 32'h0, 32'h0, 1'b0, "R7 reset state zeros");
    drive(8'h00, 8'h00, 1'b1, 32'h0, 32'h0, 1'b1, "R7 zeros with cin");
    drive(8'hFF, 8'h00, 1'b0, 32'hFFFFFFFF, 32'h0, 1'b0, "R6 propagate cin0");
    drive(8'hFF, 8'h00, 1'b1, 32'hFFFFFFFF, 32'h0, 1'b1, "R6 propagate cin1");
    drive(8'hAA, 8'h55, 1'b1, 32'hAAAAAAAA, 32'h55555555, 1'b1, "R6 alternating cin1");
    drive(8'h0F, 8'hF0, 1'b0, 32'h0000FFFF, 32'hFFFF0000, 1'b0, "R6 split cin0");
    drive(8'hFF, 8'hFF, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R8 all ones cin0");
    drive(8'hFF, 8'hFF, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R8 all ones cin1");
    drive(8'h80, 8'h80, 1'b0, 32'h80000000, 32'h80000000, 1'b0, "R5 top generate");
    drive(8'h7F, 8'h01, 1'b0, 32'h7FFFFFFF, 32'h00000001, 1'b0, "R5 no carry out");
    drive(8'hFF, 8'h01, 1'b0, 32'hFFFFFFFF, 32'h00000001, 1'b0, "R5 ripple to top");
    drive(8'h7F, 8'h80, 1'b1, 32'h7FFFFFFF, 32'h80000000, 1'b1, "R5 cin ripple");
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++)
          drive(8'(x), 8'(y), 1'(c), $urandom, $urandom, 1'($urandom), "R1 sweep");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule